// File: doc/BRIEF.md
# Security Register and Block Lock Command Interface

This block models the command decoder of a flash memory device, limited to the one-time-programmable security register and the per-block lock bits. A host writes 16-bit command words over a simple synchronous bus. These commands select what a read returns: the main array, the identification space or the status word. They can also start a program or a lock operation. Every read returns its data one cycle after the read strobe.

The security register is 128 bits wide and is seen as eight 16-bit words. The first four words hold a fixed factory value that cannot be changed. The last four form the user half, which starts all ones. A program can only turn ones into zeros. A lock word sits in front of the eight data words. Clearing its bit 1 seals the user half for good.

Each program or lock operation uses a fixed number of busy clock cycles, and the status word shows whether the block is ready. Refused operations set error flags that stay set until the host clears them.

Top module: `otp_cmd_if`

## Requirements
- R1: After reset the block is in array mode, and every read returns ARRAY_FILL (FFFFh) on `rdata` in the cycle after the read strobe. Also after reset: the status word is 0080h, the user half is all ones and unlocked, and no block is locked.
- R2: A write of 0090h selects identification mode. A write of 00FFh selects array mode. A write of 0070h selects status mode. In status mode a read returns the status word at any address.
- R3: In identification mode, offset PR_BASE+0 (80h) returns the lock word. Its bits 15:2 are ones, bit 1 is 1 while the user half is open, and bit 0 is always 0. Offsets 81h–84h return the factory value, least significant word first. Offsets 85h–88h return the user words in the same order.
- R4: A write of 00C0h followed by a write of address and data programs that word, and the new value is the old value AND the data. The second write puts the block in status mode. The new contents are visible once the busy time ends.
- R5: A program aimed at the factory words, at an address outside 80h–88h, or at a user word while the user half is locked leaves all contents unchanged and sets status bit 4.
- R6: Programming offset 80h with data bit 1 equal to 0 locks the user half for good. Bit 0 of the lock word stays 0.
- R7: Status bit 7 reads 0 during the BUSY_CYC (8) cycles after the second write of an operation, and reads 1 otherwise. Status bit 5 is the lock-clear error, bit 4 is the program/lock-set error, and all other bits are 0.
- R8: While the block is busy, every bus write is ignored, including mode commands and 0050h.
- R9: 0060h followed by 0001h sets the lock bit of the block that holds the second write's address (address bits 11:9). 0060h followed by 00D0h clears all lock bits. 0060h followed by any other data sets status bits 4 and 5 and changes no lock bit.
- R10: In identification mode, a read at a block base + 02h returns that block's lock bit on bit 0 (1 = locked) with bits 15:1 zero. Other offsets outside the register window return 0000h.
- R11: Status bits 4 and 5 stay set until a 0050h write clears both. That write does not change the read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; `wdata` is a command or operand |
| rd_en | input | 1 | Read strobe; `rdata` updates on the next edge |
| addr | input | ADDR_W (12) | Word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
The hardest case to reach from the ports is a write that arrives while an operation is still busy. Its effect is invisible unless the ignored command would have changed something the host can see afterwards. The stimulus makes this happen by starting a program that will fail, then issuing mode-change and clear-status commands inside the eight-cycle busy window. After the window it reads back, expecting status mode to still be active and the error bit to still be set. A second hard case is a sealed user half, which needs a lock-word program before any later user program can be refused. The random phase leaves the user half open so that the AND-only update rule is exercised across many data patterns first, and a directed sequence then seals it and checks the refusal.

// File: rtl/otp_pkg.sv
package otp_pkg;
   typedef enum logic [1:0] {MD_ARRAY, MD_IDENT, MD_STATUS} rd_mode_t;
   typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_SETLK, OP_CLRLK, OP_BADLK} op_t;

   localparam logic [15:0] CMD_READ_ARRAY = 16'h00FF;
   localparam logic [15:0] CMD_READ_IDENT = 16'h0090;
   localparam logic [15:0] CMD_READ_STAT  = 16'h0070;
   localparam logic [15:0] CMD_CLR_STAT   = 16'h0050;
   localparam logic [15:0] CMD_PR_SETUP   = 16'h00C0;
   localparam logic [15:0] CMD_LK_SETUP   = 16'h0060;
   localparam logic [15:0] CMD_LK_SET     = 16'h0001;
   localparam logic [15:0] CMD_LK_CLRALL  = 16'h00D0;
endpackage

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
   import otp_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int BUSY_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output rd_mode_t          mode,
   output logic              busy,
   output logic              op_go,
   output op_t               op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [15:0]       op_data,
   output logic              clr_sts
);
   localparam int CNT_W = $clog2(BUSY_CYC + 1);

   typedef enum logic [1:0] {ARM_NONE, ARM_PROG, ARM_LOCK} arm_t;

   arm_t             arm;
   logic [CNT_W-1:0] cnt;

   // completion strobe coincides with the edge that drops busy
   assign op_go = busy && (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MD_ARRAY;
         busy    <= 1'b0;
         cnt     <= '0;
         arm     <= ARM_NONE;
         op_kind <= OP_NONE;
         op_addr <= '0;
         op_data <= '0;
         clr_sts <= 1'b0;
      end else begin
         clr_sts <= 1'b0;
         if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            else                  cnt  <= cnt - CNT_W'(1);
         end else if (wr_en) begin
            case (arm)
               ARM_PROG: begin
                  op_kind <= OP_PROG;
                  op_addr <= addr;
                  op_data <= wdata;
                  busy    <= 1'b1;
                  cnt     <= CNT_W'(BUSY_CYC);
                  arm     <= ARM_NONE;
                  mode    <= MD_STATUS;
               end
               ARM_LOCK: begin
                  if (wdata == CMD_LK_SET)         op_kind <= OP_SETLK;
                  else if (wdata == CMD_LK_CLRALL) op_kind <= OP_CLRLK;
                  else                             op_kind <= OP_BADLK;
                  op_addr <= addr;
                  op_data <= wdata;
                  busy    <= 1'b1;
                  cnt     <= CNT_W'(BUSY_CYC);
                  arm     <= ARM_NONE;
                  mode    <= MD_STATUS;
               end
               default: begin
                  case (wdata)
                     CMD_READ_ARRAY: mode    <= MD_ARRAY;
                     CMD_READ_IDENT: mode    <= MD_IDENT;
                     CMD_READ_STAT:  mode    <= MD_STATUS;
                     CMD_CLR_STAT:   clr_sts <= 1'b1;
                     CMD_PR_SETUP:   arm     <= ARM_PROG;
                     CMD_LK_SETUP:   arm     <= ARM_LOCK;
                     default:        ;
                  endcase
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/otp_prot_store.sv
module otp_prot_store #(
   parameter int          ADDR_W      = 12,
   parameter int          PR_BASE     = 'h80,
   parameter int          SEG_WORDS   = 4,
   parameter logic [63:0] FACTORY_VAL = 64'hC3A5_1E2F_7B90_4D68
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    prog_go,
   input  logic [ADDR_W-1:0]       prog_addr,
   input  logic [15:0]             prog_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic                    pr_hit,
   output logic [15:0]             pr_word,
   output logic                    prog_fail,
   output logic                    user_open,
   output logic [16*SEG_WORDS-1:0] user_img
);
   localparam int USER_OFS = SEG_WORDS + 1;
   localparam int WIN_LEN  = 2 * SEG_WORDS + 1;

   logic [ADDR_W-1:0] p_off, r_off;
   logic [15:0]       uw [SEG_WORDS];
   logic              p_lockw, p_user;

   assign p_off   = prog_addr - ADDR_W'(PR_BASE);
   assign r_off   = rd_addr   - ADDR_W'(PR_BASE);
   assign p_lockw = (p_off == '0);
   assign p_user  = (p_off >= ADDR_W'(USER_OFS)) && (p_off < ADDR_W'(WIN_LEN));

   assign prog_fail = prog_go && !(p_lockw || (p_user && user_open));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  user_open <= 1'b1;
      else if (prog_go && p_lockw) user_open <= user_open & prog_data[1];
   end

   for (genvar g = 0; g < SEG_WORDS; g++) begin : g_user
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            uw[g] <= '1;
         else if (prog_go && user_open && p_off == ADDR_W'(USER_OFS + g))
            uw[g] <= uw[g] & prog_data;
      end
      assign user_img[16*g +: 16] = uw[g];
   end

   assign pr_hit = (r_off < ADDR_W'(WIN_LEN));

   always_comb begin
      pr_word = '0;
      if (r_off == '0) pr_word = {14'h3FFF, user_open, 1'b0};
      for (int i = 0; i < SEG_WORDS; i++) begin
         if (r_off == ADDR_W'(i + 1))        pr_word = FACTORY_VAL[16*i +: 16];
         if (r_off == ADDR_W'(USER_OFS + i)) pr_word = uw[i];
      end
   end
endmodule

// File: rtl/otp_blk_locks.sv
module otp_blk_locks #(
   parameter int IDX_W   = 3,
   parameter int NUM_BLK = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_go,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               clr_go,
   output logic [NUM_BLK-1:0] locks
);
   for (genvar b = 0; b < NUM_BLK; b++) begin : g_lk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 locks[b] <= 1'b0;
         else if (clr_go)                            locks[b] <= 1'b0;
         else if (set_go && set_idx == IDX_W'(b))    locks[b] <= 1'b1;
      end
   end
endmodule

// File: rtl/otp_cmd_if.sv
module otp_cmd_if
   import otp_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          BLK_SHIFT   = 9,
   parameter int          BUSY_CYC    = 8,
   parameter int          PR_BASE     = 'h80,
   parameter logic [63:0] FACTORY_VAL = 64'hC3A5_1E2F_7B90_4D68,
   parameter logic [15:0] ARRAY_FILL  = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic [15:0]       rdata
);
   localparam int IDX_W     = ADDR_W - BLK_SHIFT;
   localparam int NUM_BLK   = 1 << IDX_W;
   localparam int BLK_WORDS = 1 << BLK_SHIFT;
   localparam int SEG_WORDS = 4;
   localparam int PR_IN_BLK = PR_BASE % BLK_WORDS;

   if (BUSY_CYC < 1) begin : g_chk_busy
      $error("BUSY_CYC must be at least 1");
   end
   if (BLK_SHIFT < 4 || BLK_SHIFT >= ADDR_W) begin : g_chk_blk
      $error("BLK_SHIFT out of range");
   end
   if (PR_IN_BLK <= 2 || PR_IN_BLK + 2*SEG_WORDS >= BLK_WORDS) begin : g_chk_win
      $error("register window overlaps a lock-status offset or a block edge");
   end
   if (PR_BASE + 2*SEG_WORDS >= (1 << ADDR_W)) begin : g_chk_fit
      $error("register window outside address space");
   end

   rd_mode_t          mode;
   op_t               op_kind;
   logic              busy, op_go, clr_sts;
   logic [ADDR_W-1:0] op_addr;
   logic [15:0]       op_data;
   logic              prog_go, set_go, clr_go, bad_go;
   logic              pr_hit, prog_fail, user_open;
   logic [15:0]       pr_word;
   logic [16*SEG_WORDS-1:0] user_img;
   logic [NUM_BLK-1:0] locks;
   logic              sr_pf, sr_cf;
   logic [7:0]        status;
   logic [15:0]       rd_val;

   otp_cmd_fsm #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_fsm (
      .clk, .rst_n, .wr_en, .addr, .wdata,
      .mode, .busy, .op_go, .op_kind, .op_addr, .op_data, .clr_sts
   );

   assign prog_go = op_go && (op_kind == OP_PROG);
   assign set_go  = op_go && (op_kind == OP_SETLK);
   assign clr_go  = op_go && (op_kind == OP_CLRLK);
   assign bad_go  = op_go && (op_kind == OP_BADLK);

   otp_prot_store #(
      .ADDR_W(ADDR_W), .PR_BASE(PR_BASE), .SEG_WORDS(SEG_WORDS), .FACTORY_VAL(FACTORY_VAL)
   ) u_store (
      .clk, .rst_n, .prog_go,
      .prog_addr(op_addr), .prog_data(op_data), .rd_addr(addr),
      .pr_hit, .pr_word, .prog_fail, .user_open, .user_img
   );

   otp_blk_locks #(.IDX_W(IDX_W), .NUM_BLK(NUM_BLK)) u_locks (
      .clk, .rst_n, .set_go,
      .set_idx(op_addr[ADDR_W-1:BLK_SHIFT]), .clr_go, .locks
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_pf <= 1'b0;
         sr_cf <= 1'b0;
      end else if (clr_sts) begin
         sr_pf <= 1'b0;
         sr_cf <= 1'b0;
      end else begin
         if (prog_fail || bad_go) sr_pf <= 1'b1;
         if (bad_go)              sr_cf <= 1'b1;
      end
   end

   assign status = {~busy, 1'b0, sr_cf, sr_pf, 4'b0000};

   always_comb begin
      case (mode)
         MD_STATUS: rd_val = {8'h00, status};
         MD_IDENT: begin
            if (pr_hit)
               rd_val = pr_word;
            else if (addr[BLK_SHIFT-1:0] == BLK_SHIFT'(2))
               rd_val = {15'h0000, locks[addr[ADDR_W-1:BLK_SHIFT]]};
            else
               rd_val = '0;
         end
         default: rd_val = ARRAY_FILL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end
endmodule

// File: rtl/otp_cmd_if_chk.sv
module otp_cmd_if_chk #(
   parameter int NUM_BLK = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               rd_en,
   input logic               is_status,
   input logic [15:0]        rdata,
   input logic               prog_fail,
   input logic               bad_go,
   input logic               clr_go,
   input logic               clr_sts,
   input logic               sr_pf,
   input logic               sr_cf,
   input logic               user_open,
   input logic [63:0]        user_img,
   input logic [NUM_BLK-1:0] locks
);
   AST_USER_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((user_img & ~$past(user_img)) == 64'h0)); // R4
   AST_FAIL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_fail |=> ($stable(user_img) && $stable(user_open) && sr_pf)); // R5
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !user_open |=> !user_open); // R6
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (is_status && rd_en && busy) |=> !rdata[7]); // R7
   AST_CLR_ALL_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_go |=> (locks == '0)); // R9
   AST_BAD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      bad_go |=> (sr_pf && sr_cf)); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_pf && !clr_sts) |=> sr_pf); // R11
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sts |=> (!sr_pf && !sr_cf)); // R11
endmodule

bind otp_cmd_if otp_cmd_if_chk #(.NUM_BLK(NUM_BLK)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en),
   .is_status(mode == otp_pkg::MD_STATUS), .rdata(rdata),
   .prog_fail(prog_fail), .bad_go(bad_go), .clr_go(clr_go), .clr_sts(clr_sts),
   .sr_pf(sr_pf), .sr_cf(sr_cf), .user_open(user_open),
   .user_img(user_img), .locks(locks)
);

// File: tb/sim_otp_cmd_if.sv
module sim_otp_cmd_if;
   localparam logic [63:0] FACT = 64'hC3A5_1E2F_7B90_4D68;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;

   int checks = 0;
   int errors = 0;

   // bench model: mode 0 array, 1 ident, 2 status
   int          m_mode = 0;
   logic [15:0] m_user [4];
   logic        m_open = 1'b1;
   logic [7:0]  m_lock = '0;
   logic        m_pf = 1'b0, m_cf = 1'b0;

   always #10 clk = ~clk;

   otp_cmd_if u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [15:0] v);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; v = rdata;
   endtask

   function automatic logic [15:0] exp_stat();
      return {8'h00, 1'b1, 1'b0, m_cf, m_pf, 4'h0};
   endfunction

   function automatic logic [15:0] exp_ident(input logic [11:0] a);
      logic [11:0] o = a - 12'h080;
      if (o == 0) return {14'h3FFF, m_open, 1'b0};
      if (o >= 1 && o <= 4) return FACT[16*(o-1) +: 16];
      if (o >= 5 && o <= 8) return m_user[o-5];
      if (a[8:0] == 9'd2) return {15'h0, m_lock[a[11:9]]};
      return 16'h0000;
   endfunction

   function automatic logic [15:0] exp_read(input logic [11:0] a);
      if (m_mode == 1) return exp_ident(a);
      if (m_mode == 2) return exp_stat();
      return 16'hFFFF;
   endfunction

   task automatic rd_chk(input string req, input logic [11:0] a);
      logic [15:0] v;
      rd(a, v);
      check(req, v, exp_read(a));
   endtask

   task automatic set_mode(input logic [15:0] cmd);
      wr(12'($urandom), cmd);
      m_mode = (cmd == 16'h00FF) ? 0 : (cmd == 16'h0090) ? 1 : 2;
   endtask

   task automatic do_prog(input logic [11:0] a, input logic [15:0] d);
      logic [15:0] v;
      logic [11:0] o;
      wr(12'($urandom), 16'h00C0);
      wr(a, d);
      rd(12'($urandom), v);
      check("R7 busy", {15'h0, v[7]}, 16'h0000);
      repeat (8) @(negedge clk);
      o = a - 12'h080;
      if (o == 0) m_open = m_open & d[1];
      else if (o >= 5 && o <= 8 && m_open) m_user[o-5] = m_user[o-5] & d;
      else m_pf = 1'b1;
      m_mode = 2;
   endtask

   task automatic do_lock(input logic [11:0] a, input logic [15:0] d);
      wr(12'($urandom), 16'h0060);
      wr(a, d);
      repeat (9) @(negedge clk);
      if (d == 16'h0001) m_lock[a[11:9]] = 1'b1;
      else if (d == 16'h00D0) m_lock = '0;
      else begin m_pf = 1'b1; m_cf = 1'b1; end
      m_mode = 2;
   endtask

   task automatic clr_status();
      wr(12'($urandom), 16'h0050);
      m_pf = 1'b0; m_cf = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%04h expected=%04h", 16'h0000, 16'h0001);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd24681));
      for (int i = 0; i < 4; i++) m_user[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 array fill", 12'h123);
      set_mode(16'h0070);
      rd_chk("R1 status ready", 12'h000);
      set_mode(16'h0090);
      rd_chk("R1 lock word", 12'h080);
      rd_chk("R1 user erased", 12'h088);
      rd_chk("R1 block unlocked", 12'hE02);

      // R2 / R3 mode switching and window
      for (int k = 1; k <= 4; k++) rd_chk("R3 factory word", 12'(12'h080 + k));
      set_mode(16'h00FF);
      rd_chk("R2 array mode", 12'h081);
      set_mode(16'h0090);
      rd_chk("R2 ident mode", 12'h084);

      // R4 AND-only program
      do_prog(12'h086, 16'h00F0);
      rd_chk("R4 status mode after program", 12'h086);
      set_mode(16'h0090);
      rd_chk("R4 programmed word", 12'h086);
      do_prog(12'h086, 16'h0F30);
      set_mode(16'h0090);
      rd_chk("R4 bits only cleared", 12'h086);

      // R5 refused targets
      do_prog(12'h082, 16'h0000);
      rd_chk("R5 factory refused flag", 12'h000);
      set_mode(16'h0090);
      rd_chk("R5 factory unchanged", 12'h082);
      clr_status();
      do_prog(12'h300, 16'h0000);
      rd_chk("R5 outside window flag", 12'h000);

      // R11 clear status keeps mode
      clr_status();
      rd_chk("R11 cleared, still status", 12'h000);

      // R8 writes during busy ignored
      wr(12'h000, 16'h00C0);
      wr(12'h083, 16'h0000);
      wr(12'h000, 16'h00FF);
      wr(12'h000, 16'h0090);
      wr(12'h000, 16'h0050);
      repeat (6) @(negedge clk);
      m_pf = 1'b1; m_mode = 2;
      rd_chk("R8 busy writes ignored", 12'h081);

      // R9 / R10 block locks
      clr_status();
      do_lock(12'h605, 16'h0001);
      set_mode(16'h0090);
      rd_chk("R10 locked block", 12'h602);
      rd_chk("R10 other block", 12'h402);
      rd_chk("R10 non-lock offset", 12'h603);
      do_lock(12'h000, 16'h00D0);
      set_mode(16'h0090);
      rd_chk("R9 clear all", 12'h602);
      do_lock(12'h000, 16'h0077);
      rd_chk("R9 bad second cycle", 12'h000);
      clr_status();

      // constrained random mix, user half stays open
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 9);
         logic [11:0] a;
         logic [15:0] d;
         if ($urandom_range(0, 9) < 7) a = 12'(12'h080 + $urandom_range(0, 9));
         else a = 12'($urandom);
         d = 16'($urandom);
         case (op)
            0, 1, 2: begin
               if (a == 12'h080) d[1] = 1'b1;
               do_prog(a, d);
            end
            3:       do_lock(a, 16'h0001);
            4:       do_lock(a, ($urandom_range(0, 2) == 0) ? 16'h00D0 : 16'h0001);
            5:       do_lock(a, (d == 16'h0001 || d == 16'h00D0) ? 16'h1234 : d);
            6:       clr_status();
            7: begin
               int s = $urandom_range(0, 2);
               set_mode(s == 0 ? 16'h00FF : s == 1 ? 16'h0090 : 16'h0070);
            end
            default: begin
               if ($urandom_range(0, 1) == 0) set_mode(16'h0090);
               if ($urandom_range(0, 2) == 0)
                  a = {3'($urandom), 9'd2};
               rd_chk("R3 R10 random read", a);
            end
         endcase
      end

      // R6 seal user half
      clr_status();
      do_prog(12'h080, 16'hFFFD);
      set_mode(16'h0090);
      rd_chk("R6 lock word sealed", 12'h080);
      do_prog(12'h085, 16'h0000);
      rd_chk("R6 locked program flagged", 12'h000);
      set_mode(16'h0090);
      rd_chk("R6 user word unchanged", 12'h085);
      do_prog(12'h080, 16'hFFFF);
      set_mode(16'h0090);
      rd_chk("R6 lock stays", 12'h080);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule